// File: doc/BRIEF.md
# SMBus Register Target

This block is the byte-level part of an SMBus slave. A bit engine in front of it turns the SDA/SCL waveform into single-cycle events: a start or repeated start, a received byte, a request for the next transmit byte, and a stop. The block answers each received byte with an acknowledge decision, on the same cycle. It also supplies the byte to shift out whenever the engine asks for one. Behind the bus it holds a small file of 16-bit registers, and each register has its own block buffer together with a stored block length.

The command byte selects both the register and the way it is accessed. Bits 7:6 give the access kind: 00 for byte, 01 for word, 10 for block, and 11 is reserved. Bits 5:0 give the register index. The last valid command stays in a pointer, so later transactions reuse it:
- a repeated start followed by a read address reads the register just selected;
- a bare read transaction reads whatever register the previous command selected.

Transmit bytes are requested by the engine. The host ends a read by NACKing the last byte and then issuing a stop.

Top module: `smbus_reg_target`

## Requirements
- R1: A first byte after a start or repeated start whose bits 7:1 equal DEV_ADDR is acknowledged. Bit 0 of that byte selects the direction: 1 means the target transmits, 0 means the host writes.
- R2: A first byte with any other address is NACKed. Every byte after it is NACKed and tx_data reads 0xFF until the next start.
- R3: In a write, the byte after the address is the command. It is acknowledged and becomes the register pointer only when bits 7:6 are not 11 and bits 5:0 are below NREGS. Otherwise it is NACKed, the pointer keeps its old value, and the rest of that write is NACKed.
- R4: The pointer persists across stops and repeated starts. A write that stops right after its command changes only the pointer and no register contents.
- R5: Byte kind (00): the first data byte written replaces the low half of the selected register, and any later data bytes are NACKed and discarded. A read returns the low half first and 0xFF after that.
- R6: Word kind (01): the first data byte written goes to the low half and the second to the high half, and any third byte is NACKed. A read returns the low half, then the high half, then 0xFF.
- R7: Block kind (10): the first data byte is a count. A count up to BLK_MAX is acknowledged and becomes the stored block length. The next count bytes are stored in order, and any bytes beyond the count are NACKed and discarded. A count above BLK_MAX is NACKed, and then all further bytes are NACKed and the buffer and length stay unchanged.
- R8: A block-kind read returns the stored length as a count byte, then that many stored bytes, then 0xFF.
- R9: A read transaction that has no command before it reads from the register and kind held in the pointer.
- R10: After reset the pointer is 0x00 (byte kind, register 0), all registers and lengths are zero, and tx_data is 0xFF outside a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| rx_valid | input | 1 | A byte from the host is in rx_data |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | The engine has taken tx_data for transmission |
| bus_stop | input | 1 | Stop seen on the bus |
| rx_ack | output | 1 | Acknowledge for the byte in rx_data, valid while rx_valid is high |
| tx_data | output | 8 | Byte to transmit next |

## Verification
The bound checker checks the following on every cycle:
- address acceptance and rejection, and the silence that follows a foreign address;
- rejection of a reserved command, with the pointer left unchanged;
- the upper limit on acknowledged bytes in one transaction;
- that the pointer moves only on a received byte.

Some behaviour depends on stored contents and on the order of transactions, so only the bench scenarios can show it:
- the low-then-high order of word data;
- count-prefixed block replies;
- truncation of block writes at the declared count;
- reads that rely on a pointer set by an earlier transaction.

// File: rtl/smbus_reg_target.sv
module smbus_reg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int NREGS = 8,
  parameter int BLK_MAX = 32
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_req,
  input  logic       bus_stop,
  output logic       rx_ack,
  output logic [7:0] tx_data
);
  localparam int RI_W  = $clog2(NREGS);
  localparam int BI_W  = $clog2(BLK_MAX);
  localparam int LEN_W = $clog2(BLK_MAX + 1);
  localparam int IDX_W = $clog2(BLK_MAX + 2) + 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WDAT, S_RD} st_t;

  st_t              st;
  logic [1:0]       ptr_kind;
  logic [RI_W-1:0]  ptr_reg;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] wcnt;
  logic             cnt_ok;

  logic [15:0]      regs    [NREGS];
  logic [7:0]       blk     [NREGS][BLK_MAX];
  logic [LEN_W-1:0] blk_len [NREGS];

  wire addr_hit = rx_data[7:1] == DEV_ADDR;
  wire cmd_ok   = rx_data[7:6] != 2'b11 && int'(rx_data[5:0]) < NREGS;
  wire cnt_fits = int'(rx_data) <= BLK_MAX;

  logic wr_ack;
  always_comb begin
    case (ptr_kind)
      2'b00:   wr_ack = idx == '0;
      2'b01:   wr_ack = int'(idx) < 2;
      2'b10:   wr_ack = (idx == '0) ? cnt_fits
                                    : (cnt_ok && int'(idx) - 1 < int'(wcnt));
      default: wr_ack = 1'b0;
    endcase
  end

  always_comb begin
    case (st)
      S_ADDR:  rx_ack = rx_valid && addr_hit;
      S_CMD:   rx_ack = rx_valid && cmd_ok;
      S_WDAT:  rx_ack = rx_valid && wr_ack;
      default: rx_ack = 1'b0;
    endcase
  end

  logic [7:0] rd_byte;
  always_comb begin
    rd_byte = 8'hFF;
    case (ptr_kind)
      2'b00: if (idx == '0) rd_byte = regs[ptr_reg][7:0];
      2'b01: begin
        if (idx == '0)                  rd_byte = regs[ptr_reg][7:0];
        else if (idx == IDX_W'(1))      rd_byte = regs[ptr_reg][15:8];
      end
      2'b10: begin
        if (idx == '0) rd_byte = 8'(blk_len[ptr_reg]);
        else if (int'(idx) <= int'(blk_len[ptr_reg]))
          rd_byte = blk[ptr_reg][BI_W'(idx - IDX_W'(1))];
      end
      default: rd_byte = 8'hFF;
    endcase
  end

  assign tx_data = (st == S_RD) ? rd_byte : 8'hFF;

  wire [IDX_W-1:0] idx_inc = (idx == '1) ? idx : idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr_kind <= 2'b00;
      ptr_reg  <= '0;
      idx      <= '0;
      wcnt     <= '0;
      cnt_ok   <= 1'b0;
      for (int r = 0; r < NREGS; r++) begin
        regs[r]    <= '0;
        blk_len[r] <= '0;
        for (int b = 0; b < BLK_MAX; b++) blk[r][b] <= '0;
      end
    end else if (bus_start) begin
      st  <= S_ADDR;
      idx <= '0;
    end else if (bus_stop) begin
      st <= S_IDLE;
    end else if (rx_valid) begin
      case (st)
        S_ADDR: begin
          idx <= '0;
          st  <= !addr_hit ? S_IDLE : (rx_data[0] ? S_RD : S_CMD);
        end
        S_CMD: begin
          idx <= '0;
          if (cmd_ok) begin
            ptr_kind <= rx_data[7:6];
            ptr_reg  <= rx_data[RI_W-1:0];
            st       <= S_WDAT;
          end else begin
            st <= S_IDLE;
          end
        end
        S_WDAT: begin
          idx <= idx_inc;
          if (ptr_kind == 2'b10 && idx == '0) begin
            cnt_ok <= cnt_fits;
            if (cnt_fits) begin
              wcnt             <= rx_data[LEN_W-1:0];
              blk_len[ptr_reg] <= rx_data[LEN_W-1:0];
            end
          end else if (wr_ack) begin
            case (ptr_kind)
              2'b00:   regs[ptr_reg][7:0] <= rx_data;
              2'b01:   if (idx == '0) regs[ptr_reg][7:0]  <= rx_data;
                       else           regs[ptr_reg][15:8] <= rx_data;
              default: blk[ptr_reg][BI_W'(idx - IDX_W'(1))] <= rx_data;
            endcase
          end
        end
        default: ;
      endcase
    end else if (tx_req && st == S_RD) begin
      idx <= idx_inc;
    end
  end
endmodule

// File: rtl/smbus_reg_target_chk.sv
module smbus_reg_target_chk #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int BLK_MAX = 32,
  parameter int PTR_W = 5
)(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_start,
  input logic             bus_stop,
  input logic             rx_valid,
  input logic [7:0]       rx_data,
  input logic             rx_ack,
  input logic [7:0]       tx_data,
  input logic [PTR_W-1:0] ptr
);
  logic       first_q, ignore_q, cmd_q;
  logic [6:0] acks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b0; ignore_q <= 1'b0; cmd_q <= 1'b0; acks <= '0;
    end else if (bus_start) begin
      first_q <= 1'b1; ignore_q <= 1'b0; cmd_q <= 1'b0; acks <= '0;
    end else if (bus_stop) begin
      first_q <= 1'b0; cmd_q <= 1'b0;
    end else if (rx_valid) begin
      first_q <= 1'b0;
      cmd_q   <= first_q && rx_ack && !rx_data[0];
      if (first_q) ignore_q <= !rx_ack;
      if (rx_ack && acks != '1) acks <= acks + 7'd1;
    end
  end

  // R1
  addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_q && rx_valid && rx_data[7:1] == DEV_ADDR |-> rx_ack);
  // R2
  foreign_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_q && rx_valid && rx_data[7:1] != DEV_ADDR |-> !rx_ack);
  // R2
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignore_q && rx_valid |-> !rx_ack);
  // R2
  ignore_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignore_q |-> tx_data == 8'hFF);
  // R3
  reserved_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q && rx_valid && rx_data[7:6] == 2'b11 |-> !rx_ack);
  // R3
  cmd_reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q && rx_valid && !rx_ack && !bus_start |=> $stable(ptr));
  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_valid) |-> $stable(ptr));
  // R7
  ack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ack |-> int'(acks) < BLK_MAX + 3);
endmodule

bind smbus_reg_target smbus_reg_target_chk #(
  .DEV_ADDR(DEV_ADDR), .BLK_MAX(BLK_MAX), .PTR_W(2 + $clog2(NREGS))
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_ack(rx_ack),
  .tx_data(tx_data), .ptr({ptr_kind, ptr_reg})
);

// File: tb/test_smbus_reg_target.sv
`timescale 1ns/100ps
module test_smbus_reg_target;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_start = 0, rx_valid = 0, tx_req = 0, bus_stop = 0;
  logic [7:0] rx_data = 0;
  logic rx_ack;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  smbus_reg_target #(.DEV_ADDR(DEV), .NREGS(8), .BLK_MAX(32)) i_smbus_reg_target (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_req(tx_req), .bus_stop(bus_stop),
    .rx_ack(rx_ack), .tx_data(tx_data));

  int vectors = 0, fails = 0;
  logic [15:0] m_word [8];
  logic [7:0]  m_blk  [8][32];
  int          m_len  [8];
  logic [7:0]  m_ptr;
  logic [7:0]  pl [40];

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); bus_start = 1; @(posedge clk); #1 bus_start = 0;
  endtask
  task automatic do_stop();
    @(negedge clk); bus_stop = 1; @(posedge clk); #1 bus_stop = 0;
  endtask
  task automatic put_byte(logic [7:0] b, logic exp_ack, string req);
    @(negedge clk); rx_valid = 1; rx_data = b; #1;
    check(req, {7'd0, rx_ack}, {7'd0, exp_ack});
    @(posedge clk); #1 rx_valid = 0;
  endtask
  task automatic get_byte(logic [7:0] exp, string req);
    @(negedge clk); tx_req = 1; #1;
    check(req, tx_data, exp);
    @(posedge clk); #1 tx_req = 0;
  endtask

  function automatic logic cmd_valid(logic [7:0] c);
    return c[7:6] != 2'b11 && c[5:0] < 6'd8;
  endfunction

  function automatic logic [7:0] exp_rd(int k);
    int r = int'(m_ptr[2:0]);
    case (m_ptr[7:6])
      2'b00: return (k == 0) ? m_word[r][7:0] : 8'hFF;
      2'b01: return (k == 0) ? m_word[r][7:0] : (k == 1) ? m_word[r][15:8] : 8'hFF;
      default: return (k == 0) ? 8'(m_len[r]) : (k <= m_len[r]) ? m_blk[r][k-1] : 8'hFF;
    endcase
  endfunction

  function automatic string kind_tag();
    case (m_ptr[7:6])
      2'b00: return "R5";
      2'b01: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic write_txn(logic [6:0] a, logic [7:0] cmd, int n);
    logic v; int cnt; logic e; string tg; int r;
    do_start();
    put_byte({a, 1'b0}, a == DEV, a == DEV ? "R1" : "R2");
    if (a != DEV) begin
      put_byte(cmd, 1'b0, "R2");
      for (int i = 0; i < n; i++) put_byte(pl[i], 1'b0, "R2");
      do_stop();
      return;
    end
    v = cmd_valid(cmd);
    put_byte(cmd, v, "R3");
    if (v) m_ptr = cmd;
    r = int'(cmd[2:0]);
    cnt = -1;
    for (int i = 0; i < n; i++) begin
      e = 1'b0; tg = "R3";
      if (v) begin
        case (cmd[7:6])
          2'b00: begin tg = "R5"; e = (i == 0); if (e) m_word[r][7:0] = pl[i]; end
          2'b01: begin
            tg = "R6"; e = (i < 2);
            if (i == 0) m_word[r][7:0] = pl[i];
            if (i == 1) m_word[r][15:8] = pl[i];
          end
          default: begin
            tg = "R7";
            if (i == 0) begin
              e = pl[i] <= 8'd32;
              if (e) begin cnt = int'(pl[i]); m_len[r] = cnt; end
            end else begin
              e = (i - 1) < cnt;
              if (e) m_blk[r][i-1] = pl[i];
            end
          end
        endcase
      end
      put_byte(pl[i], e, tg);
    end
    do_stop();
  endtask

  task automatic read_txn(logic [6:0] a, int n, logic use_cmd, logic [7:0] cmd, string tag);
    string tg;
    do_start();
    if (use_cmd) begin
      put_byte({DEV, 1'b0}, 1'b1, "R1");
      put_byte(cmd, cmd_valid(cmd), "R3");
      if (cmd_valid(cmd)) m_ptr = cmd;
      do_start();
    end
    put_byte({a, 1'b1}, a == DEV, a == DEV ? "R1" : "R2");
    tg = (tag.len() != 0) ? tag : kind_tag();
    for (int k = 0; k < n; k++)
      get_byte(a == DEV ? exp_rd(k) : 8'hFF, a == DEV ? tg : "R2");
    do_stop();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int r = 0; r < 8; r++) begin
      m_word[r] = '0; m_len[r] = 0;
      for (int b = 0; b < 32; b++) m_blk[r][b] = '0;
    end
    m_ptr = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R10 reset state
    @(negedge clk); #1 check("R10", tx_data, 8'hFF);
    read_txn(DEV, 2, 0, 8'h00, "R10");

    // R6 word write low then high, read low first
    pl[0] = 8'h34; pl[1] = 8'h12; pl[2] = 8'h99;
    write_txn(DEV, 8'h41, 3);
    read_txn(DEV, 3, 1, 8'h41, "R6");

    // R5 byte write touches only low half
    pl[0] = 8'hAB; pl[1] = 8'hCD;
    write_txn(DEV, 8'h01, 2);
    read_txn(DEV, 2, 1, 8'h01, "R5");
    read_txn(DEV, 3, 1, 8'h41, "R6");

    // R7 block write with extra byte, R8 block read
    pl[0] = 8'd3; pl[1] = 8'h11; pl[2] = 8'h22; pl[3] = 8'h33; pl[4] = 8'h44;
    write_txn(DEV, 8'h83, 5);
    read_txn(DEV, 5, 1, 8'h83, "R8");
    // R7 oversized count rejected, buffer unchanged
    pl[0] = 8'd33; pl[1] = 8'h55; pl[2] = 8'h66;
    write_txn(DEV, 8'h83, 3);
    read_txn(DEV, 5, 1, 8'h83, "R8");
    // R7 full block plus one
    pl[0] = 8'd32;
    for (int i = 1; i < 34; i++) pl[i] = 8'(i * 7);
    write_txn(DEV, 8'h84, 34);
    read_txn(DEV, 34, 1, 8'h84, "R8");

    // R4 command-only write, then R9 bare read
    write_txn(DEV, 8'h41, 0);
    read_txn(DEV, 3, 0, 8'h00, "R9");
    read_txn(DEV, 3, 0, 8'h00, "R4");

    // R3 reserved kind and out-of-range index
    pl[0] = 8'h77;
    write_txn(DEV, 8'hC1, 1);
    write_txn(DEV, 8'h09, 1);
    read_txn(DEV, 3, 0, 8'h00, "R3");

    // R2 foreign address
    pl[0] = 8'h5A;
    write_txn(7'h2B, 8'h01, 1);
    read_txn(7'h11, 2, 0, 8'h00, "R2");
    read_txn(DEV, 3, 0, 8'h00, "R4");

    for (int t = 0; t < 400; t++) begin
      logic [6:0] a; logic [7:0] c; int n; int op;
      a = ($urandom_range(0, 9) == 0) ? 7'($urandom_range(0, 127)) : DEV;
      c = {2'($urandom_range(0, 3)), 6'($urandom_range(0, 9))};
      op = int'($urandom_range(0, 2));
      if (op == 0) begin
        if (c[7:6] == 2'b10) begin
          pl[0] = 8'($urandom_range(0, 34));
          n = int'(pl[0]) + 1 + int'($urandom_range(0, 2));
          if (n > 40) n = 40;
        end else n = int'($urandom_range(0, 3));
        for (int i = (c[7:6] == 2'b10) ? 1 : 0; i < n; i++) pl[i] = 8'($urandom);
        write_txn(a, c, n);
      end else if (op == 1) begin
        read_txn(a, int'($urandom_range(1, 36)), 1'b0, 8'h00, "");
      end else begin
        read_txn(DEV, int'($urandom_range(1, 36)), 1'b1, c, "");
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule